// File: doc/BRIEF.md
# Asynchronous Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide asynchronous flash device. It drives the chip select, output enable and write enable strobes, the 17-bit address bus and the bidirectional data bus. The host submits one request at a time on a valid/ready handshake. A request is one of four kinds: program one byte, erase one sector, erase the whole chip, or return the device to read mode. The block expands each request into the device's unlock-and-command write sequence. Every strobe width comes from a nanosecond minimum rounded up to whole clock cycles.

After a program or erase command, the block polls the target address. It compares data bit 7 with the value the operation should leave there. A clear bit 5 means keep waiting. A set bit 5 forces exactly one more read, because bits 7 and 5 can flip on the same access. A poll budget stops a device that never finishes. The outcome is reported as a one-cycle result with a code. Every failure is followed by the device's three-write return-to-read sequence before the next request can be taken.

Top module: `flash_prog_ctrl`

## Requirements
- R1: Reset state. After reset, `req_ready` is 1, `fl_cs_n`, `fl_oe_n` and `fl_we_n` are 1, `fl_dq_oe` is 0 and `res_valid` is 0.
- R2: Program (`req_op`=0) issues four writes, in this order (address/data):
  - 5555h/AAh
  - 2AAAh/55h
  - 5555h/A0h
  - the request address / the request byte
- R3: Both erases issue six writes: AAh, 55h, 80h, AAh, 55h, each at the unlock addresses 5555h/2AAAh/5555h/5555h/2AAAh, then a final write.
  - Chip erase (`req_op`=2) ends with 10h at 5555h.
  - Sector erase (`req_op`=1) ends with 30h at the request address.
- R4: A return-to-read request (`req_op`=3) issues 5555h/AAh, 2AAAh/55h, 5555h/F0h. It performs no read and reports code 0.
- R5: Write strobe timing. Each write enable low pulse lasts exactly WE_LO cycles (4 at defaults). Write enable stays high at least WE_HI cycles (2) between pulses.
- R6: Read timing and bus safety.
  - Each poll read holds output enable low for RD_CYC cycles (7).
  - The data bus is never driven while output enable is low.
  - After output enable rises, at least FLOAT_CYC cycles (2) pass before the bus is driven.
- R7: Polling reads the request address. Bit 7 is compared with the programmed byte's bit 7 (program) or with 1 (erase). A match reports code 0. A mismatch with bit 5 clear triggers another read.
- R8: A mismatch with bit 5 set triggers exactly one more read. If bit 7 then matches, code 0 is reported.
- R9: If that extra read still mismatches, code 1 is reported. `req_ready` stays 0 until the return-to-read sequence of R4 has been written.
- R10: If POLL_LIMIT reads all mismatch with bit 5 clear, code 2 is reported, followed by the return-to-read sequence.
- R11: A request is accepted only while `req_ready` is 1. A request held during a running operation has no effect. Each result is a one-cycle `res_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 return to read |
| req_addr | input | 17 | Byte address or any address in the sector |
| req_data | input | 8 | Byte to program |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 2 | 0 pass, 1 device reported timeout, 2 poll budget exhausted |
| fl_addr | output | 17 | Flash address bus |
| fl_dq_out | output | 8 | Data driven to flash |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_dq_in | input | 8 | Data read from flash |
| fl_cs_n | output | 1 | Chip select, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The hardest case to reach from the ports is the one where bit 5 and bit 7 change on the same access, so the forced extra read is the one that decides the result. The bench holds a flash model that counts poll reads and scripts each read's status byte per scenario. It can return a plain busy byte, then a byte with the timeout bit set and bit 7 still wrong, then either the true value or a further failing byte. The exact number of reads and the trailing return-to-read writes then show whether the extra read happened once and was judged correctly.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

    localparam int FL_AW = 17;
    localparam int FL_DW = 8;

    localparam logic [FL_AW-1:0] UNLK_A = 17'h05555;
    localparam logic [FL_AW-1:0] UNLK_B = 17'h02AAA;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_RST  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_DEVFAIL = 2'd1,
        RES_WDOG    = 2'd2
    } res_e;

    typedef enum logic [2:0] {
        V_PASS,
        V_AGAIN,
        V_RECHECK,
        V_FAIL_DEV,
        V_FAIL_WD
    } verdict_e;

    typedef enum logic [2:0] {
        T_IDLE,
        T_WRITE,
        T_WWAIT,
        T_READ,
        T_RWAIT
    } top_st_e;

    typedef struct packed {
        logic [FL_AW-1:0] addr;
        logic [FL_DW-1:0] data;
    } bus_wr_t;

    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [2:0] seq_last(input op_e op);
        return (op == OP_PROG) ? 3'd3 : (op == OP_RST) ? 3'd2 : 3'd5;
    endfunction

    function automatic bus_wr_t cmd_step(input op_e op, input logic [2:0] idx,
                                         input logic [FL_AW-1:0] ta,
                                         input logic [FL_DW-1:0] td);
        bus_wr_t w;
        w.addr = UNLK_A;
        w.data = 8'hAA;
        case (idx)
            3'd1: begin w.addr = UNLK_B; w.data = 8'h55; end
            3'd2: w.data = (op == OP_PROG) ? 8'hA0 : (op == OP_RST) ? 8'hF0 : 8'h80;
            3'd3: if (op == OP_PROG) begin w.addr = ta; w.data = td; end
            3'd4: begin w.addr = UNLK_B; w.data = 8'h55; end
            3'd5: if (op == OP_CHIP) w.data = 8'h10;
                  else begin w.addr = ta; w.data = 8'h30; end
            default: ;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/flash_bus_engine.sv
module flash_bus_engine
    import flash_ctrl_pkg::*;
#(
    parameter int WE_LO     = 4,
    parameter int WE_HI     = 2,
    parameter int RD_CYC    = 7,
    parameter int FLOAT_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             go_write,
    input  logic [FL_AW-1:0] go_addr,
    input  logic [FL_DW-1:0] go_data,
    output logic             done,
    output logic [FL_DW-1:0] rdata,
    output logic [FL_AW-1:0] fl_addr,
    output logic [FL_DW-1:0] fl_dq_out,
    output logic             fl_dq_oe,
    input  logic [FL_DW-1:0] fl_dq_in,
    output logic             fl_cs_n,
    output logic             fl_oe_n,
    output logic             fl_we_n
);

    localparam int MAXC = max2(max2(WE_LO, WE_HI), max2(RD_CYC, FLOAT_CYC));
    localparam int CW   = $clog2(MAXC + 1);

    typedef enum logic [2:0] {E_IDLE, E_WSET, E_WLO, E_WHI, E_RACC, E_RFLT} eng_st_e;

    eng_st_e          st;
    logic [CW-1:0]    cnt;
    logic [FL_AW-1:0] a_q;
    logic [FL_DW-1:0] d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= E_IDLE;
            cnt   <= '0;
            a_q   <= '0;
            d_q   <= '0;
            rdata <= '0;
        end else begin
            case (st)
                E_IDLE: if (go) begin
                    a_q <= go_addr;
                    d_q <= go_data;
                    st  <= go_write ? E_WSET : E_RACC;
                    cnt <= go_write ? '0 : CW'(RD_CYC - 1);
                end
                E_WSET: begin
                    st  <= E_WLO;
                    cnt <= CW'(WE_LO - 1);
                end
                E_WLO: if (cnt == '0) begin
                    st  <= E_WHI;
                    cnt <= CW'(WE_HI - 1);
                end else cnt <= cnt - 1'b1;
                E_WHI: if (cnt == '0) st <= E_IDLE;
                       else cnt <= cnt - 1'b1;
                E_RACC: if (cnt == '0) begin
                    rdata <= fl_dq_in;
                    st    <= E_RFLT;
                    cnt   <= CW'(FLOAT_CYC - 1);
                end else cnt <= cnt - 1'b1;
                E_RFLT: if (cnt == '0) st <= E_IDLE;
                        else cnt <= cnt - 1'b1;
                default: st <= E_IDLE;
            endcase
        end
    end

    assign done      = ((st == E_WHI) || (st == E_RFLT)) && (cnt == '0);
    assign fl_cs_n   = !((st == E_WSET) || (st == E_WLO) || (st == E_WHI) || (st == E_RACC));
    assign fl_oe_n   = (st != E_RACC);
    assign fl_we_n   = (st != E_WLO);
    assign fl_dq_oe  = (st == E_WSET) || (st == E_WLO) || (st == E_WHI);
    assign fl_addr   = a_q;
    assign fl_dq_out = d_q;

    // checker counters for strobe widths
    logic [CW:0] lo_run, hi_run, flt_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_run  <= '0;
            hi_run  <= (CW+1)'(MAXC);
            flt_run <= (CW+1)'(MAXC);
        end else begin
            lo_run  <= fl_we_n ? '0 : lo_run + 1'b1;
            hi_run  <= !fl_we_n ? '0 : (hi_run < (CW+1)'(MAXC)) ? hi_run + 1'b1 : hi_run;
            flt_run <= !fl_oe_n ? '0 : (flt_run < (CW+1)'(MAXC)) ? flt_run + 1'b1 : flt_run;
        end
    end

    a_r5_we_low_width: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> lo_run == (CW+1)'(WE_LO));
    a_r5_we_high_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_we_n) |-> hi_run >= (CW+1)'(WE_HI));
    a_r6_float_before_drive: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_dq_oe) |-> flt_run >= (CW+1)'(FLOAT_CYC));

endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge
    import flash_ctrl_pkg::*;
(
    input  logic     bit7,
    input  logic     bit5,
    input  logic     exp7,
    input  logic     recheck,
    input  logic     at_limit,
    output verdict_e verdict
);
    always_comb begin
        if (bit7 == exp7)  verdict = V_PASS;
        else if (recheck)  verdict = V_FAIL_DEV;
        else if (bit5)     verdict = V_RECHECK;
        else if (at_limit) verdict = V_FAIL_WD;
        else               verdict = V_AGAIN;
    end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_ctrl_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter int T_WC_NS    = 70,
    parameter int T_WP_NS    = 35,
    parameter int T_WPH_NS   = 20,
    parameter int T_AH_NS    = 45,
    parameter int T_DS_NS    = 30,
    parameter int T_ACC_NS   = 70,
    parameter int T_OE_NS    = 30,
    parameter int T_DF_NS    = 20,
    parameter int POLL_LIMIT = 65536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [FL_AW-1:0] req_addr,
    input  logic [FL_DW-1:0] req_data,
    output logic             res_valid,
    output logic [1:0]       res_code,
    output logic [FL_AW-1:0] fl_addr,
    output logic [FL_DW-1:0] fl_dq_out,
    output logic             fl_dq_oe,
    input  logic [FL_DW-1:0] fl_dq_in,
    output logic             fl_cs_n,
    output logic             fl_oe_n,
    output logic             fl_we_n
);

    localparam int WE_LO     = max2(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
    localparam int WE_HI     = max2(1, max2(ns2cyc(T_WPH_NS, CLK_NS),
                                    max2(ns2cyc(T_WC_NS, CLK_NS) - WE_LO - 1,
                                         ns2cyc(T_AH_NS, CLK_NS) - WE_LO)));
    localparam int RD_CYC    = max2(1, max2(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)));
    localparam int FLOAT_CYC = max2(1, ns2cyc(T_DF_NS, CLK_NS));
    localparam int PW        = $clog2(POLL_LIMIT + 1);

    top_st_e          st;
    op_e              op_q;
    logic [FL_AW-1:0] addr_q;
    logic [FL_DW-1:0] data_q;
    logic [2:0]       step_q;
    logic [PW-1:0]    poll_cnt;
    logic             recheck_q;
    logic             quiet_q;

    logic             eng_done;
    logic [FL_DW-1:0] eng_rdata;
    bus_wr_t          wr;
    verdict_e         verdict;
    logic             exp7;

    assign req_ready = (st == T_IDLE);
    assign wr        = cmd_step(op_q, step_q, addr_q, data_q);
    assign exp7      = (op_q == OP_PROG) ? data_q[7] : 1'b1;

    flash_bus_engine #(
        .WE_LO(WE_LO), .WE_HI(WE_HI), .RD_CYC(RD_CYC), .FLOAT_CYC(FLOAT_CYC)
    ) u_eng (
        .clk(clk), .rst(rst),
        .go((st == T_WRITE) || (st == T_READ)),
        .go_write(st == T_WRITE),
        .go_addr((st == T_WRITE) ? wr.addr : addr_q),
        .go_data(wr.data),
        .done(eng_done), .rdata(eng_rdata),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_cs_n(fl_cs_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    flash_poll_judge u_judge (
        .bit7(eng_rdata[7]), .bit5(eng_rdata[5]), .exp7(exp7),
        .recheck(recheck_q), .at_limit(poll_cnt == PW'(POLL_LIMIT - 1)),
        .verdict(verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= T_IDLE;
            op_q      <= OP_RST;
            addr_q    <= '0;
            data_q    <= '0;
            step_q    <= '0;
            poll_cnt  <= '0;
            recheck_q <= 1'b0;
            quiet_q   <= 1'b0;
            res_valid <= 1'b0;
            res_code  <= RES_OK;
        end else begin
            res_valid <= 1'b0;
            case (st)
                T_IDLE: if (req_valid) begin
                    op_q      <= op_e'(req_op);
                    addr_q    <= req_addr;
                    data_q    <= req_data;
                    step_q    <= '0;
                    poll_cnt  <= '0;
                    recheck_q <= 1'b0;
                    quiet_q   <= 1'b0;
                    st        <= T_WRITE;
                end
                T_WRITE: st <= T_WWAIT;
                T_WWAIT: if (eng_done) begin
                    if (step_q == seq_last(op_q)) begin
                        if (op_q == OP_RST) begin
                            if (!quiet_q) begin
                                res_valid <= 1'b1;
                                res_code  <= RES_OK;
                            end
                            st <= T_IDLE;
                        end else st <= T_READ;
                    end else begin
                        step_q <= step_q + 1'b1;
                        st     <= T_WRITE;
                    end
                end
                T_READ: st <= T_RWAIT;
                T_RWAIT: if (eng_done) begin
                    case (verdict)
                        V_PASS: begin
                            res_valid <= 1'b1;
                            res_code  <= RES_OK;
                            st        <= T_IDLE;
                        end
                        V_AGAIN: begin
                            poll_cnt <= poll_cnt + 1'b1;
                            st       <= T_READ;
                        end
                        V_RECHECK: begin
                            recheck_q <= 1'b1;
                            st        <= T_READ;
                        end
                        default: begin
                            res_valid <= 1'b1;
                            res_code  <= (verdict == V_FAIL_DEV) ? RES_DEVFAIL : RES_WDOG;
                            op_q      <= OP_RST;
                            step_q    <= '0;
                            quiet_q   <= 1'b1;
                            st        <= T_WRITE;
                        end
                    endcase
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    a_r11_idle_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> fl_cs_n && fl_we_n);
    a_r11_result_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
    a_r9_fail_holds_ready: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_code != RES_OK) |-> !req_ready);
    a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !fl_dq_oe);
    a_r10_poll_bound: assert property (@(posedge clk) disable iff (rst)
        poll_cnt <= PW'(POLL_LIMIT - 1));
    a_r8_single_recheck: assert property (@(posedge clk) disable iff (rst)
        (st == T_RWAIT && eng_done && recheck_q) |=> (st != T_READ));

endmodule

// File: tb/flash_prog_ctrl_test.sv
module flash_prog_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        res_valid;
    logic [1:0]  res_code;
    logic [16:0] fl_addr;
    logic [7:0]  fl_dq_out;
    logic        fl_dq_oe;
    logic [7:0]  rd_val = 8'h00;
    logic        fl_cs_n, fl_oe_n, fl_we_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prog_ctrl #(.POLL_LIMIT(LIMIT)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .res_valid(res_valid), .res_code(res_code),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(rd_val), .fl_cs_n(fl_cs_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    // flash model and bus monitor
    localparam int M_NORMAL = 0, M_TO_OK = 1, M_TO_BAD = 2, M_HANG = 3;
    int          m_mode = M_NORMAL;
    int          m_busy = 0;
    logic [7:0]  m_final = 8'hFF;
    logic        m_exp7 = 1'b1;
    logic [16:0] exp_raddr = '0;
    logic [16:0] wa [16];
    logic [7:0]  wd [16];
    int wn = 0, rn = 0, raddr_bad = 0;
    int we_run = 0, oe_run = 0, hi_run = 100;
    int we_bad = 0, oe_bad = 0, gap_bad = 0, cont_bad = 0;
    logic p_we = 1'b1, p_oe = 1'b1;
    logic [16:0] cur_wa = '0;

    function automatic logic [7:0] respond(input int k);
        logic [7:0] busy;
        busy = {~m_exp7, k[0], 6'b0};
        case (m_mode)
            M_NORMAL: return (k < m_busy) ? busy : m_final;
            M_TO_OK:  return (k == 0) ? busy : (k == 1) ? (busy | 8'h20) : m_final;
            M_TO_BAD: return (k == 0) ? busy : (busy | 8'h20);
            default:  return busy;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (!fl_oe_n && fl_dq_oe) cont_bad++;
            if (p_we && !fl_we_n) begin
                cur_wa = fl_addr;
                if (hi_run < 2) gap_bad++;
            end
            if (!p_we && fl_we_n) begin
                if (we_run != 4) we_bad++;
                if (wn < 16) begin wa[wn] = cur_wa; wd[wn] = fl_dq_out; end
                wn++;
            end
            we_run = fl_we_n ? 0 : we_run + 1;
            hi_run = fl_we_n ? hi_run + 1 : 0;
            if (p_oe && !fl_oe_n) begin
                rd_val = respond(rn);
                if (fl_addr != exp_raddr) raddr_bad++;
                rn++;
            end
            if (!p_oe && fl_oe_n && oe_run != 7) oe_bad++;
            oe_run = fl_oe_n ? 0 : oe_run + 1;
            p_we = fl_we_n;
            p_oe = fl_oe_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_wr(input int i, input logic [16:0] a, input logic [7:0] d, input string req);
        chk(wa[i] == a, req, int'(wa[i]), int'(a));
        chk(wd[i] == d, req, int'(wd[i]), int'(d));
    endtask

    task automatic setup(input int mode, input int busy, input logic [7:0] fin,
                         input logic e7, input logic [16:0] ra);
        m_mode = mode; m_busy = busy; m_final = fin; m_exp7 = e7; exp_raddr = ra;
        wn = 0; rn = 0; raddr_bad = 0;
    endtask

    // issue a request, wait for its result and for the block to go idle again
    task automatic run_req(input logic [1:0] op, input logic [16:0] a, input logic [7:0] d,
                           output logic [1:0] code, output logic rdy_at_res);
        int guard;
        @(negedge clk);
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!res_valid && guard < 5000) begin @(negedge clk); guard++; end
        code = res_code;
        rdy_at_res = req_ready;
        while (!req_ready && guard < 5000) begin @(negedge clk); guard++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_state;
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk({fl_cs_n, fl_oe_n, fl_we_n} == 3'b111, "R1 strobes", int'({fl_cs_n, fl_oe_n, fl_we_n}), 7);
        chk(fl_dq_oe == 1'b0, "R1 dq_oe", int'(fl_dq_oe), 0);
        chk(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
    endtask

    task automatic t_program;
        logic [1:0] c; logic r;
        setup(M_NORMAL, 3, 8'h5A, 1'b0, 17'h12345);
        run_req(2'd0, 17'h12345, 8'h5A, c, r);
        chk(wn == 4, "R2 write count", wn, 4);
        chk_wr(0, 17'h05555, 8'hAA, "R2 w0");
        chk_wr(1, 17'h02AAA, 8'h55, "R2 w1");
        chk_wr(2, 17'h05555, 8'hA0, "R2 w2");
        chk_wr(3, 17'h12345, 8'h5A, "R2 w3");
        chk(rn == 4, "R7 poll reads busy3", rn, 4);
        chk(raddr_bad == 0, "R7 poll address", raddr_bad, 0);
        chk(c == 2'd0, "R7 pass code", int'(c), 0);
    endtask

    task automatic t_program_hi;
        logic [1:0] c; logic r;
        setup(M_NORMAL, 0, 8'hC3, 1'b1, 17'h00010);
        run_req(2'd0, 17'h00010, 8'hC3, c, r);
        chk(rn == 1, "R7 single read bit7=1", rn, 1);
        chk(c == 2'd0, "R7 pass code bit7=1", int'(c), 0);
    endtask

    task automatic t_sector;
        logic [1:0] c; logic r;
        setup(M_NORMAL, 2, 8'hFF, 1'b1, 17'h1C010);
        run_req(2'd1, 17'h1C010, 8'h00, c, r);
        chk(wn == 6, "R3 sector write count", wn, 6);
        chk_wr(2, 17'h05555, 8'h80, "R3 sector setup");
        chk_wr(3, 17'h05555, 8'hAA, "R3 sector w3");
        chk_wr(4, 17'h02AAA, 8'h55, "R3 sector w4");
        chk_wr(5, 17'h1C010, 8'h30, "R3 sector final");
        chk(rn == 3 && raddr_bad == 0, "R7 sector poll", rn, 3);
        chk(c == 2'd0, "R7 sector pass", int'(c), 0);
    endtask

    task automatic t_chip;
        logic [1:0] c; logic r;
        setup(M_NORMAL, 1, 8'hFF, 1'b1, 17'h04000);
        run_req(2'd2, 17'h04000, 8'h00, c, r);
        chk(wn == 6, "R3 chip write count", wn, 6);
        chk_wr(5, 17'h05555, 8'h10, "R3 chip final");
        chk(rn == 2 && c == 2'd0, "R3 chip poll pass", rn, 2);
    endtask

    task automatic t_rstreq;
        logic [1:0] c; logic r;
        setup(M_NORMAL, 0, 8'hFF, 1'b1, 17'h0);
        run_req(2'd3, 17'h0ABCD, 8'h00, c, r);
        chk(wn == 3, "R4 write count", wn, 3);
        chk_wr(0, 17'h05555, 8'hAA, "R4 w0");
        chk_wr(1, 17'h02AAA, 8'h55, "R4 w1");
        chk_wr(2, 17'h05555, 8'hF0, "R4 w2");
        chk(rn == 0 && c == 2'd0, "R4 no read, pass", rn, 0);
    endtask

    task automatic t_to_ok;
        logic [1:0] c; logic r;
        setup(M_TO_OK, 0, 8'h80, 1'b1, 17'h00100);
        run_req(2'd0, 17'h00100, 8'h80, c, r);
        chk(rn == 3, "R8 recheck read count", rn, 3);
        chk(c == 2'd0, "R8 recheck pass", int'(c), 0);
        chk(wn == 4, "R8 no reset writes", wn, 4);
    endtask

    task automatic t_to_bad;
        logic [1:0] c; logic r;
        setup(M_TO_BAD, 0, 8'hFF, 1'b1, 17'h08000);
        run_req(2'd1, 17'h08000, 8'h00, c, r);
        chk(rn == 3, "R9 read count", rn, 3);
        chk(c == 2'd1, "R9 fail code", int'(c), 1);
        chk(r == 1'b0, "R9 ready low at result", int'(r), 0);
        chk(wn == 9, "R9 write count incl reset", wn, 9);
        chk_wr(6, 17'h05555, 8'hAA, "R9 reset w0");
        chk_wr(7, 17'h02AAA, 8'h55, "R9 reset w1");
        chk_wr(8, 17'h05555, 8'hF0, "R9 reset w2");
    endtask

    task automatic t_hang;
        logic [1:0] c; logic r;
        setup(M_HANG, 0, 8'h00, 1'b0, 17'h00F00);
        run_req(2'd0, 17'h00F00, 8'h11, c, r);
        chk(rn == LIMIT, "R10 read budget", rn, LIMIT);
        chk(c == 2'd2, "R10 watchdog code", int'(c), 2);
        chk(r == 1'b0 && wn == 7, "R10 reset follows", wn, 7);
        chk_wr(6, 17'h05555, 8'hF0, "R10 reset last");
    endtask

    task automatic t_busy_ignore;
        int guard;
        int pulses;
        setup(M_NORMAL, 4, 8'h00, 1'b0, 17'h00200);
        @(negedge clk);
        req_op = 2'd0; req_addr = 17'h00200; req_data = 8'h00; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_op = 2'd3;
        repeat (20) @(negedge clk);
        req_valid = 1'b0;
        guard = 0; pulses = 0;
        while (!req_ready && guard < 5000) begin
            if (res_valid) pulses++;
            @(negedge clk); guard++;
        end
        repeat (3) begin if (res_valid) pulses++; @(negedge clk); end
        chk(wn == 4, "R11 held request ignored", wn, 4);
        chk(pulses == 1, "R11 one result pulse", pulses, 1);
    endtask

    task automatic t_timing;
        chk(we_bad == 0, "R5 we low width", we_bad, 0);
        chk(gap_bad == 0, "R5 we high gap", gap_bad, 0);
        chk(oe_bad == 0, "R6 oe low width", oe_bad, 0);
        chk(cont_bad == 0, "R6 no contention", cont_bad, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_program();
        t_program_hi();
        t_sector();
        t_chip();
        t_rstreq();
        t_to_ok();
        t_to_bad();
        t_hang();
        t_busy_ignore();
        t_timing();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule